// File: doc/BRIEF.md
# Infrared Pulse Encoder for a Serial Transmitter

This block sits between a UART transmitter and an infrared transceiver. It reshapes the transmitter's serial bit stream into short infrared pulses. Every zero bit becomes one narrow pulse near the middle of its bit cell. One bits send no light. The infrared drive pin is active low, so the LED is lit while that output is low. While infrared mode is in use, the ordinary wired transmit line is parked high, in the idle marking level.

The block has two pulse-width modes. In the fractional mode a pulse lasts three of the sixteen baud sub-ticks that make up a bit cell, so its width scales with the bit rate. In the fixed mode a pulse lasts three periods of a separate slow reference tick, whatever the bit rate. It is cut short if it would run past the end of its bit cell. A loopback control returns the pulse stream, in receive polarity, to the receive path in place of the external infrared input. The UART supplies the sub-tick, a cell-start marker and the bit value. The reference tick comes from a divider outside the block.

Top module: `sir_encoder`

## Requirements
- R1: A phase counter steps 0..15 on each `baud_tick` and wraps from 15 to 0. A `baud_tick` with `cell_sync` high forces the phase to 0 and latches `tx_bit` as the bit of the new cell. `cell_sync` is ignored without `baud_tick`.
- R2: Fractional mode (`low_power`=0 when the pulse starts). For a zero cell bit, `ir_out_n` goes low on the clock after the tick that moves the phase from 5 to 6. It returns high on the clock after the tick that moves the phase from 8 to 9. That is exactly three sub-tick intervals.
- R3: Fixed mode (`low_power`=1 when the pulse starts). The pulse starts at the same point as in R2. It ends on the clock after the third `lp_tick` that follows the start cycle. An `lp_tick` in the start cycle itself does not count.
- R4: A cell whose latched bit is 1 produces no pulse.
- R5: Infrared is active only when `uart_en` and `sir_en` are both 1. While it is inactive, `ir_out_n` is 1 from the next clock on, and a pulse in progress is dropped.
- R6: While infrared is active, `txd` is 1. Otherwise `txd` follows `tx_bit` combinationally.
- R7: With `uart_en`=0, `sir_en` has no effect: `txd` follows `tx_bit` and `ir_out_n` stays 1.
- R8: With `loop_en`=1, `ir_rx` equals the inverse of `ir_out_n`. With `loop_en`=0, `ir_rx` equals `ir_in`.
- R9: A pulse still running when a cell boundary tick arrives is ended by that tick. A boundary tick is one that takes the phase to 0, either by `cell_sync` or by wrapping.
- R10: During and just after synchronous reset (`rst`=1), `ir_out_n` is 1, the phase is 0 and the latched bit is 1.
- R11: The width mode is sampled once, when a pulse starts. A change of `low_power` during a pulse does not change how that pulse ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| uart_en | input | 1 | Whole-UART enable |
| sir_en | input | 1 | Infrared mode select |
| low_power | input | 1 | 1 = fixed-width pulses timed by `lp_tick` |
| loop_en | input | 1 | Loopback of the pulse stream to `ir_rx` |
| baud_tick | input | 1 | One-cycle strobe, 16 per bit cell |
| cell_sync | input | 1 | With `baud_tick`, marks the first sub-tick of a cell |
| tx_bit | input | 1 | Serial transmit bit from the UART |
| lp_tick | input | 1 | One-cycle strobe of the low-power reference |
| ir_in | input | 1 | External infrared receive input |
| txd | output | 1 | Wired transmit line |
| ir_out_n | output | 1 | Infrared drive, active low |
| ir_rx | output | 1 | Infrared stream toward the receive path |

## Verification
The bench goes after the pulse edges at the phase 6 and phase 9 ticks. A design off by one sub-tick there would show a pulse width other than three tick intervals. It drives fixed-mode runs with a slow reference, so that a design without the cell-boundary cut-off leaves the LED lit into the next cell. It also uses early cell resyncs, which catch a phase counter that does not restart. Random toggles of `low_power` and `sir_en` mid-pulse expose designs that resample the mode or fail to drop a live pulse. Runs with the UART disabled and runs in loopback catch a `txd` parked high or a receive mux in the wrong polarity.

// File: rtl/sir_enc_pkg.sv
package sir_enc_pkg;

    typedef enum logic {
        WIDTH_FRAC  = 1'b0,
        WIDTH_FIXED = 1'b1
    } pulse_mode_e;

    typedef struct packed {
        logic to_start;
        logic to_end;
        logic to_edge;
    } cell_evt_t;

    function automatic int unsigned wrap_inc(int unsigned v, int unsigned lim);
        return (v + 1 >= lim) ? 0 : v + 1;
    endfunction

    function automatic pulse_mode_e pick_mode(logic low_power);
        return low_power ? WIDTH_FIXED : WIDTH_FRAC;
    endfunction

endpackage

// File: rtl/sir_cell_timer.sv
module sir_cell_timer
    import sir_enc_pkg::*;
#(
    parameter int unsigned TICKS_PER_BIT = 16,
    parameter int unsigned PULSE_START   = 6,
    parameter int unsigned PULSE_TICKS   = 3
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      baud_tick,
    input  logic      cell_sync,
    input  logic      tx_bit,
    output logic      cell_bit,
    output cell_evt_t evt
);
    localparam int unsigned PH_W    = $clog2(TICKS_PER_BIT);
    localparam int unsigned END_PH  = PULSE_START + PULSE_TICKS;

    logic [PH_W-1:0] phase;
    logic [PH_W-1:0] phase_nxt;

    always_comb begin
        phase_nxt = cell_sync ? '0 : PH_W'(wrap_inc(int'(phase), TICKS_PER_BIT));
        evt.to_start = baud_tick && (phase_nxt == PH_W'(PULSE_START));
        evt.to_end   = baud_tick && (phase_nxt == PH_W'(END_PH));
        evt.to_edge  = baud_tick && (phase_nxt == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= '0;
            cell_bit <= 1'b1;
        end else if (baud_tick) begin
            phase <= phase_nxt;
            if (cell_sync) begin
                cell_bit <= tx_bit;
            end
        end
    end

    AST_SYNC_RESTART: assert property (@(posedge clk) disable iff (rst)
        (baud_tick && cell_sync) |=> (phase == '0)); // R1

endmodule

// File: rtl/sir_pulse_gen.sv
module sir_pulse_gen
    import sir_enc_pkg::*;
#(
    parameter int unsigned PULSE_TICKS = 3,
    parameter int unsigned LP_TICKS    = 3
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      active,
    input  logic      low_power,
    input  logic      lp_tick,
    input  logic      baud_tick,
    input  logic      cell_bit,
    input  cell_evt_t evt,
    output logic      pulse_on
);
    localparam int unsigned LC_W = $clog2(LP_TICKS + 1);
    localparam int unsigned TK_W = $clog2(PULSE_TICKS + 1);

    pulse_mode_e     mode;
    logic [LC_W-1:0] lp_cnt;

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            pulse_on <= 1'b0;
            lp_cnt   <= '0;
            mode     <= WIDTH_FRAC;
        end else if (evt.to_edge) begin
            pulse_on <= 1'b0;
        end else if (evt.to_start && !cell_bit) begin
            pulse_on <= 1'b1;
            mode     <= pick_mode(low_power);
            lp_cnt   <= '0;
        end else if (pulse_on) begin
            if (mode == WIDTH_FRAC) begin
                if (evt.to_end) begin
                    pulse_on <= 1'b0;
                end
            end else if (lp_tick) begin
                if (lp_cnt == LC_W'(LP_TICKS - 1)) begin
                    pulse_on <= 1'b0;
                end else begin
                    lp_cnt <= lp_cnt + 1'b1;
                end
            end
        end
    end

    // sub-tick count of a live fractional pulse, kept for the width check
    logic [TK_W-1:0] tk_cnt;
    always_ff @(posedge clk) begin
        if (rst || !pulse_on || mode != WIDTH_FRAC) begin
            tk_cnt <= '0;
        end else if (baud_tick) begin
            tk_cnt <= tk_cnt + 1'b1;
        end
    end

    AST_FRAC_WIDTH: assert property (@(posedge clk) disable iff (rst)
        (pulse_on && mode == WIDTH_FRAC) |-> (tk_cnt < TK_W'(PULSE_TICKS))); // R2
    AST_START_ZERO_ONLY: assert property (@(posedge clk) disable iff (rst)
        $rose(pulse_on) |-> $past(evt.to_start && !cell_bit)); // R4
    AST_DARK_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !active |=> !pulse_on); // R5
    AST_CELL_CUTOFF: assert property (@(posedge clk) disable iff (rst)
        evt.to_edge |=> !pulse_on); // R9

endmodule

// File: rtl/sir_line_mux.sv
module sir_line_mux (
    input  logic active,
    input  logic loop_en,
    input  logic tx_bit,
    input  logic ir_in,
    input  logic pulse_on,
    output logic txd,
    output logic ir_out_n,
    output logic ir_rx
);
    always_comb begin
        ir_out_n = ~pulse_on;
        txd      = active ? 1'b1 : tx_bit;
        ir_rx    = loop_en ? ~ir_out_n : ir_in;
    end
endmodule

// File: rtl/sir_encoder.sv
module sir_encoder
    import sir_enc_pkg::*;
#(
    parameter int unsigned TICKS_PER_BIT = 16,
    parameter int unsigned PULSE_START   = 6,
    parameter int unsigned PULSE_TICKS   = 3,
    parameter int unsigned LP_TICKS      = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic uart_en,
    input  logic sir_en,
    input  logic low_power,
    input  logic loop_en,
    input  logic baud_tick,
    input  logic cell_sync,
    input  logic tx_bit,
    input  logic lp_tick,
    input  logic ir_in,
    output logic txd,
    output logic ir_out_n,
    output logic ir_rx
);
    logic      active;
    logic      cell_bit;
    logic      pulse_on;
    cell_evt_t evt;

    assign active = uart_en && sir_en;

    sir_cell_timer #(
        .TICKS_PER_BIT(TICKS_PER_BIT),
        .PULSE_START  (PULSE_START),
        .PULSE_TICKS  (PULSE_TICKS)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .baud_tick(baud_tick),
        .cell_sync(cell_sync),
        .tx_bit   (tx_bit),
        .cell_bit (cell_bit),
        .evt      (evt)
    );

    sir_pulse_gen #(
        .PULSE_TICKS(PULSE_TICKS),
        .LP_TICKS   (LP_TICKS)
    ) u_pulse (
        .clk      (clk),
        .rst      (rst),
        .active   (active),
        .low_power(low_power),
        .lp_tick  (lp_tick),
        .baud_tick(baud_tick),
        .cell_bit (cell_bit),
        .evt      (evt),
        .pulse_on (pulse_on)
    );

    sir_line_mux u_mux (
        .active  (active),
        .loop_en (loop_en),
        .tx_bit  (tx_bit),
        .ir_in   (ir_in),
        .pulse_on(pulse_on),
        .txd     (txd),
        .ir_out_n(ir_out_n),
        .ir_rx   (ir_rx)
    );

    AST_LOOP_RETURN: assert property (@(posedge clk) disable iff (rst)
        loop_en |-> (ir_rx == !ir_out_n)); // R8
    AST_WIRE_MARKING: assert property (@(posedge clk) disable iff (rst)
        (uart_en && sir_en) |-> txd); // R6

endmodule

// File: tb/sir_encoder_test.sv
module sir_encoder_test;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst = 1'b1, uart_en = 1'b0, sir_en = 1'b0, low_power = 1'b0, loop_en = 1'b0;
    logic baud_tick = 1'b0, cell_sync = 1'b0, tx_bit = 1'b1, lp_tick = 1'b0, ir_in = 1'b0;
    logic txd, ir_out_n, ir_rx;

    sir_encoder uut (
        .clk(clk), .rst(rst), .uart_en(uart_en), .sir_en(sir_en),
        .low_power(low_power), .loop_en(loop_en), .baud_tick(baud_tick),
        .cell_sync(cell_sync), .tx_bit(tx_bit), .lp_tick(lp_tick), .ir_in(ir_in),
        .txd(txd), .ir_out_n(ir_out_n), .ir_rx(ir_rx)
    );

    int n_chk = 0, n_bad = 0;
    string cur_tag = "R10";
    bit gen_on = 0, chk_on = 0, wmon_on = 0, rnd_sync = 0, done = 0;
    int fmode = 0;            // 0 random bits, 1 all zero, 2 all one
    int tick_div = 3, lp_div = 5;
    int tdc = 0, ldc = 0, tick_in_cell = 15, low_run = 0, cyc = 0;

    task automatic chk(string req, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_int(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // stimulus generator: sub-ticks, cell markers, bits, reference ticks
    always @(negedge clk) begin
        baud_tick = 1'b0; lp_tick = 1'b0; cell_sync = 1'b0;
        if (gen_on) begin
            tdc++;
            if (tdc >= tick_div) begin
                tdc = 0;
                baud_tick = 1'b1;
                tick_in_cell++;
                if (tick_in_cell >= 16 || (rnd_sync && $urandom_range(0, 40) == 0)) begin
                    tick_in_cell = 0;
                    cell_sync = 1'b1;
                    tx_bit = (fmode == 1) ? 1'b0 : (fmode == 2) ? 1'b1 : 1'($urandom_range(0, 1));
                end
            end
            ldc++;
            if (ldc >= lp_div) begin
                ldc = 0;
                lp_tick = 1'b1;
            end
            ir_in = 1'($urandom_range(0, 1));
        end
    end

    // expected behaviour, one register step per clock, from the requirements
    int m_phase = 0, m_cnt = 0, nxt;
    logic m_bit = 1'b1, m_pulse = 1'b0, m_lp = 1'b0;
    always @(posedge clk) begin
        nxt = cell_sync ? 0 : (m_phase + 1) % 16;
        if (rst) begin
            m_phase <= 0; m_bit <= 1'b1; m_pulse <= 1'b0; m_lp <= 1'b0; m_cnt <= 0;
        end else begin
            if (baud_tick) begin
                m_phase <= nxt;
                if (cell_sync) m_bit <= tx_bit;
            end
            if (!(uart_en && sir_en)) begin
                m_pulse <= 1'b0; m_cnt <= 0;
            end else if (baud_tick && nxt == 0) begin
                m_pulse <= 1'b0;                         // R9 boundary cut
            end else if (baud_tick && nxt == 6 && !m_bit) begin
                m_pulse <= 1'b1; m_lp <= low_power; m_cnt <= 0;
            end else if (m_pulse) begin
                if (!m_lp) begin
                    if (baud_tick && nxt == 9) m_pulse <= 1'b0;
                end else if (lp_tick) begin
                    if (m_cnt == 2) m_pulse <= 1'b0;
                    else m_cnt <= m_cnt + 1;
                end
            end
        end
    end

    // output checks, sampled mid-high phase of the clock
    always @(posedge clk) begin
        #5;
        if (chk_on && !done) begin
            chk(uart_en ? cur_tag : "R7", ir_out_n, !m_pulse);
            chk(uart_en ? "R6" : "R7", txd, (uart_en && sir_en) ? 1'b1 : tx_bit);
            chk("R8", ir_rx, loop_en ? !ir_out_n : ir_in);
            if (ir_out_n === 1'b0) begin
                low_run++;
            end else begin
                if (low_run > 0 && wmon_on) chk_int("R2", low_run, 3 * tick_div);
                low_run = 0;
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    task automatic run(int n, string tag);
        cur_tag = tag;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        void'($urandom(1234));
        repeat (3) @(negedge clk);
        chk("R10", ir_out_n, 1'b1);
        chk("R10", txd, 1'b1);
        @(negedge clk);
        rst = 1'b0;
        gen_on = 1; chk_on = 1;
        uart_en = 1'b1;
        run(600, "R5");                              // SIR off: dark
        sir_en = 1'b1; wmon_on = 1;
        run(2000, "R2");                             // random bits, fractional
        fmode = 1; run(500, "R2");                   // all zeros
        fmode = 2; run(500, "R4");                   // all ones: no pulses
        fmode = 0; wmon_on = 0; rnd_sync = 1;
        run(1500, "R1");                             // early resyncs
        rnd_sync = 0; low_power = 1'b1; lp_div = 5;
        run(2000, "R3");                             // fixed width fits cell
        fmode = 1; lp_div = 40;
        run(1500, "R9");                             // fixed width truncated
        fmode = 0; lp_div = 7; cur_tag = "R11";
        repeat (1500) begin
            @(negedge clk);
            if ($urandom_range(0, 9) == 0) low_power = ~low_power;
        end
        low_power = 1'b0; cur_tag = "R5";
        repeat (1000) begin
            @(negedge clk);
            if ($urandom_range(0, 49) == 0) sir_en = ~sir_en;
        end
        sir_en = 1'b1; uart_en = 1'b0;
        run(600, "R7");                              // UART off: SIR ignored
        uart_en = 1'b1; loop_en = 1'b1; fmode = 1;
        run(800, "R8");
        sir_en = 1'b0;
        run(300, "R8");
        loop_en = 1'b0;
        run(200, "R5");
        chk_on = 0;
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule